// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter clocked by one of eight fixed taps of a free-running prescaler on the system clock. The counter serves either as an interval timer, which flags each overflow and raises an interrupt request to the processor, or as a watchdog, which drives a fixed-length overflow pulse to the outside of the chip.

Software reaches the block over a byte-wide bus with a one-bit address. Address 0 is the control/status byte. It holds the overflow flag, the mode select, the run enable and the tap select. Address 1 is the counter itself, which can be read and loaded. The overflow flag is protected against stray writes. A write of 0 clears it only when the last access before that write was a read that found the flag set.

Top module: `wdog_itimer`

## Requirements
- R1: The control/status byte at address 0 reads as {flag[7], mode[6], run[5], 1[4], 1[3], tap[2:0]}. Mode 1 selects watchdog and mode 0 selects interval. A write to address 0 loads mode from bit 6, run from bit 5 and tap from bits 2:0.
- R2: Bits 4 and 3 of the control/status byte always read as 1, and written values in those bits are ignored.
- R3: Tap codes 0 to 7 select counter ticks every 2, 64, 128, 512, 2048, 8192, 32768 and 131072 system clocks. After run is set, the first increment follows that many clocks, and each tick lasts a single cycle.
- R4: While run is 0, the counter and the prescaler are held at zero, and a counter load has no effect. While run is 1, the counter increments once per tick.
- R5: Reading address 1 returns the counter. Writing address 1 while running loads the counter. Overflow is the wrap from 0xFF to 0x00, which falls 256 ticks after run is set.
- R6: In interval mode, an overflow sets the flag. The interrupt output is high whenever the flag is 1 and interval mode is selected.
- R7: In watchdog mode, an overflow drives the watchdog output high for exactly 128 system clocks and leaves the flag unchanged.
- R8: The flag clears only on a write with bit 7 = 0 whose preceding control/status access was a read that saw the flag at 1. A write with bit 7 = 1, or a clear write with no such read, leaves the flag set.
- R9: After reset the control/status byte reads 0x18, the counter reads 0x00, and both outputs are low.
- R10: An overflow in the same cycle as a valid clear write leaves the flag at 1.
- R11: Any write to address 0 discards the armed read state, so a later clear write needs a fresh read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status byte, 1 = counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq_interval | output | 1 | Interval-mode overflow interrupt request |
| wdog_ovf_o | output | 1 | Watchdog overflow pulse |

## Verification
The hardest case to reach is an overflow landing in the exact cycle of an armed clear write. The wrap instant depends on the prescaler phase, which the ports do not show. The bench therefore first arms the flag with a read and then steps its own behavioural model one clock at a time. When the model predicts a wrap on the next edge, the bench drives the clear write in that same cycle. The watchdog pulse length and the tap periods are measured by counting clocks from the enabling write to the observed output change.

// File: rtl/wdog_itimer_pkg.sv
package wdog_itimer_pkg;

  localparam int DATA_W    = 8;
  localparam int DIV_W     = 17;
  localparam int PULSE_LEN = 128;

  typedef struct packed {
    logic       mode;  // 1 = watchdog, 0 = interval
    logic       run;
    logic [2:0] tap;
  } ctl_t;

  // log2 of the division ratio for each tap code
  function automatic logic [4:0] tap_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 5'd1;
      3'd1:    return 5'd6;
      3'd2:    return 5'd7;
      3'd3:    return 5'd9;
      3'd4:    return 5'd11;
      3'd5:    return 5'd13;
      3'd6:    return 5'd15;
      default: return 5'd17;
    endcase
  endfunction

  // low-bit mask whose all-ones state marks the last clock of a period
  function automatic logic [DIV_W-1:0] tap_mask(input logic [2:0] sel);
    logic [DIV_W:0] one;
    one = {{DIV_W{1'b0}}, 1'b1};
    return DIV_W'((one << tap_shift(sel)) - one);
  endfunction

endpackage

// File: rtl/wdi_prescaler.sv
module wdi_prescaler
  import wdog_itimer_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [W-1:0] div_q;
  logic [W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  assign mask = W'(tap_mask(sel));
  assign tick = run && ((div_q & mask) == mask);
endmodule

// File: rtl/wdi_counter.sv
module wdi_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  assign wrap = run && tick && !load && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdi_ctrl.sv
module wdi_ctrl
  import wdog_itimer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_ctl,
  input  logic       wr_ctl,
  input  logic       wr_flag_bit,
  input  ctl_t       wr_fields,
  input  logic       wrap,
  output ctl_t       ctl_q,
  output logic       flag_q,
  output logic       flag_set,
  output logic       flag_clr
);
  logic armed_q;

  assign flag_set = wrap && !ctl_q.mode;
  assign flag_clr = wr_ctl && armed_q && !wr_flag_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= wr_fields;
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (wr_ctl)                armed_q <= 1'b0;
      else if (rd_ctl && flag_q) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdi_stretch.sv
module wdi_stretch #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int HW = $clog2(LEN + 1);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (trig)         left_q <= HW'(LEN);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer
  import wdog_itimer_pkg::*;
#(
  parameter int CW  = DATA_W,
  parameter int DW  = DIV_W,
  parameter int PLS = PULSE_LEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq_interval,
  output logic          wdog_ovf_o
);
  // named internal events, also seen by the bound checker
  logic rd_ctl, wr_ctl, wr_cnt;
  logic tick, ovf_evt, flag_q, flag_set, flag_clr;
  ctl_t ctl_q, wr_fields;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] ctl_byte;

  assign rd_ctl = bus_sel && !bus_wr && !bus_addr;
  assign wr_ctl = bus_sel &&  bus_wr && !bus_addr;
  assign wr_cnt = bus_sel &&  bus_wr &&  bus_addr;

  assign wr_fields = '{mode: bus_wdata[6], run: bus_wdata[5], tap: bus_wdata[2:0]};

  wdi_prescaler #(.W(DW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .sel(ctl_q.tap), .tick(tick)
  );

  wdi_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .tick(tick),
    .load(wr_cnt), .load_val(bus_wdata), .cnt_q(cnt_q), .wrap(ovf_evt)
  );

  wdi_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .rd_ctl(rd_ctl), .wr_ctl(wr_ctl),
    .wr_flag_bit(bus_wdata[7]), .wr_fields(wr_fields), .wrap(ovf_evt),
    .ctl_q(ctl_q), .flag_q(flag_q), .flag_set(flag_set), .flag_clr(flag_clr)
  );

  wdi_stretch #(.LEN(PLS)) u_pls (
    .clk(clk), .rst_n(rst_n), .trig(ovf_evt && ctl_q.mode), .pulse(wdog_ovf_o)
  );

  assign ctl_byte     = CW'({flag_q, ctl_q.mode, ctl_q.run, 2'b11, ctl_q.tap});
  assign bus_rdata    = bus_addr ? cnt_q : ctl_byte;
  assign irq_interval = flag_q && !ctl_q.mode;
endmodule

// File: rtl/wdog_itimer_chk.sv
module wdog_itimer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_addr,
  input logic [7:0] bus_rdata,
  input logic       tick,
  input logic       ovf_evt,
  input logic       run,
  input logic       mode,
  input logic       wr_ctl,
  input logic       flag_clr,
  input logic       flag_q,
  input logic [7:0] cnt_q,
  input logic       wdog_ovf_o
);
  AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> bus_rdata[4:3] == 2'b11); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> cnt_q == 8'h00); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt_q == 8'h00); // R5
  AST_IVL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !mode) |=> flag_q); // R6
  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && mode) |=> wdog_ovf_o); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_ctl) |=> flag_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !mode && flag_clr) |=> flag_q); // R10
endmodule

bind wdog_itimer wdog_itimer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .tick(tick), .ovf_evt(ovf_evt), .run(ctl_q.run), .mode(ctl_q.mode),
  .wr_ctl(wr_ctl), .flag_clr(flag_clr), .flag_q(flag_q), .cnt_q(cnt_q),
  .wdog_ovf_o(wdog_ovf_o)
);

// File: tb/wdog_itimer_tb_top.sv
`timescale 1ns/1ps
module wdog_itimer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_interval, wdog_ovf_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  wdog_itimer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_interval(irq_interval), .wdog_ovf_o(wdog_ovf_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int periods [8] = '{2, 64, 128, 512, 2048, 8192, 32768, 131072};
  int m_div = 0, m_cnt = 0, m_tap = 0, m_hold = 0;
  bit m_flag = 0, m_armed = 0, m_mode = 0, m_run = 0;

  function automatic bit m_tick();
    return m_run && ((m_div + 1) % periods[m_tap] == 0);
  endfunction

  always @(posedge clk) begin
    bit t, wrap, cw, cr, nw;
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_tap = 0; m_hold = 0;
      m_flag = 0; m_armed = 0; m_mode = 0; m_run = 0;
    end else begin
      cw = bus_sel && bus_wr && !bus_addr;
      cr = bus_sel && !bus_wr && !bus_addr;
      nw = bus_sel && bus_wr && bus_addr;
      t  = m_tick();
      wrap = t && !nw && (m_cnt == 255);
      if (wrap && m_mode) m_hold = 128;
      else if (m_hold > 0) m_hold--;
      if (wrap && !m_mode) m_flag = 1;
      else if (cw && m_armed && !bus_wdata[7]) m_flag = 0;
      else if (cr && m_flag) m_armed = 1;
      if (cw) m_armed = 0;
      if (!m_run)    m_cnt = 0;
      else if (nw)   m_cnt = bus_wdata;
      else if (t)    m_cnt = (m_cnt + 1) % 256;
      m_div = m_run ? (m_div + 1) % 131072 : 0;
      if (cw) begin
        m_mode = bus_wdata[6]; m_run = bus_wdata[5]; m_tap = bus_wdata[2:0];
      end
    end
  end

  // every-cycle comparison, away from the edges
  always @(negedge clk) begin
    logic [7:0] er;
    #3;
    if (rst_n && !done) begin
      er = bus_addr ? 8'(m_cnt)
                    : {m_flag, m_mode, m_run, 2'b11, 3'(m_tap)};
      chk("R1 rdata vs model", bus_rdata, er);
      chk("R6 irq vs model", irq_interval, m_flag && !m_mode);
      chk("R7 wdog vs model", wdog_ovf_o, m_hold > 0);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = 1;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_addr = 1;
  endtask

  // clocks from the end of the last write until cond on a port becomes true
  task automatic count_until_cnt_nonzero(output int n);
    n = 0; #3;
    while (bus_rdata == 8'h00 && n < 300000) begin @(negedge clk); #3; n++; end
  endtask

  initial begin
    logic [7:0] v;
    int n, m;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9 reset state
    rd_reg(0, v); chk("R9 ctrl after reset", v, 8'h18);
    rd_reg(1, v); chk("R9 counter after reset", v, 8'h00);
    chk("R9 irq after reset", irq_interval, 1'b0);
    chk("R9 wdog after reset", wdog_ovf_o, 1'b0);

    // R1 / R2 field layout and reserved bits
    wr_reg(0, 8'h47); rd_reg(0, v); chk("R1 mode+tap readback", v, 8'h5F);
    wr_reg(0, 8'h00); rd_reg(0, v); chk("R2 reserved read 1", v, 8'h18);

    // R4 load ignored while stopped
    wr_reg(1, 8'h55); repeat (5) @(negedge clk);
    rd_reg(1, v); chk("R4 counter held while stopped", v, 8'h00);

    // R3 tap periods
    for (int c = 0; c < 5; c++) begin
      wr_reg(0, 8'h00);
      wr_reg(0, 8'h20 | 8'(c));
      count_until_cnt_nonzero(n);
      chk($sformatf("R3 first tick tap %0d", c), n, periods[c]);
    end

    // R4 stop mid-count clears the counter
    wr_reg(0, 8'h00); rd_reg(1, v); chk("R4 stop clears counter", v, 8'h00);

    // R5 / R6 interval overflow after 256 ticks of divide-by-2
    wr_reg(0, 8'h20);
    n = 0; #3;
    while (!irq_interval && n < 5000) begin @(negedge clk); #3; n++; end
    chk("R5 overflow period", n, 512);
    rd_reg(1, v); chk("R5 counter after wrap", v < 8'h04, 1'b1);

    // R8 clear protocol
    wr_reg(0, 8'h20); chk("R8 clear without read", irq_interval, 1'b1);
    rd_reg(0, v);     chk("R6 flag visible", v, 8'hB8);
    wr_reg(0, 8'hA0); chk("R8 write 1 no effect", irq_interval, 1'b1);
    wr_reg(0, 8'h20); chk("R11 arming dropped by write", irq_interval, 1'b1);
    rd_reg(0, v); wr_reg(0, 8'h20);
    chk("R8 read then write 0 clears", irq_interval, 1'b0);

    // R5 counter load while running
    wr_reg(1, 8'h80); rd_reg(1, v);
    chk("R5 counter load", v >= 8'h80 && v <= 8'h82, 1'b1);

    // R10 overflow coincides with armed clear
    n = 0; #3;
    while (!irq_interval && n < 5000) begin @(negedge clk); #3; n++; end
    rd_reg(0, v);
    @(negedge clk); #4;
    while (!(m_tick() && m_cnt == 255)) begin @(negedge clk); #4; end
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h20;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = 1;
    #3 chk("R10 set wins over clear", irq_interval, 1'b1);

    // R7 watchdog pulse
    rd_reg(0, v); wr_reg(0, 8'h00);
    chk("R8 flag cleared before watchdog", irq_interval, 1'b0);
    wr_reg(0, 8'h60);
    n = 0; #3;
    while (!wdog_ovf_o && n < 5000) begin @(negedge clk); #3; n++; end
    chk("R7 watchdog overflow time", n, 512);
    m = 0;
    while (wdog_ovf_o && m < 1000) begin @(negedge clk); #3; m++; end
    chk("R7 watchdog pulse length", m, 128);
    rd_reg(0, v); chk("R7 flag untouched in watchdog", v[7], 1'b0);
    chk("R7 no interrupt in watchdog", irq_interval, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule